// File: doc/BRIEF.md
# Multi-Mode USART Clock Generator

This block produces the bit timing for a serial transmitter and receiver pair. A programmable down-counter divides the system clock into a base tick. Two control bits and a direction bit then choose how that tick is used. In the two asynchronous modes the tick is the oversampling strobe, and a bit period spans either 16 ticks (normal) or 8 ticks (double speed). In synchronous master mode the block drives a transfer clock that toggles on every tick. In synchronous slave mode it ignores the divider and takes its bit strobes from a synchronized, edge-detected copy of an external transfer clock.

The transmit strobe marks where a new bit is launched and the receive strobe marks where a bit is captured. In the synchronous modes the two fall on opposite edges of the transfer clock. Loading a new divisor restarts the divider, the oversampling count and the master transfer clock, so a rate change takes effect on a clean phase.

Top module: `usart_clkgen`

## Requirements
- R1: While rst_n is low, sample_tick, tx_bit_en, rx_bit_en, xck_out and xck_oe are all 0.
- R2: In an asynchronous mode (sync_mode=0) with divisor D, sample_tick is a one-cycle pulse that repeats every D+1 clock cycles.
- R3: A div_load pulse, sampled on clock edge E0, restarts the divider. No tick follows from the old count. The first sample_tick is high in the cycle after edge E0+D+2, and the oversampling count restarts at zero.
- R4: In normal asynchronous mode (sync_mode=0, dbl_speed=0), tx_bit_en and rx_bit_en both pulse together with every 16th sample_tick after a load, starting with the 16th.
- R5: In double-speed asynchronous mode (sync_mode=0, dbl_speed=1), tx_bit_en and rx_bit_en both pulse together with every 8th sample_tick after a load, starting with the 8th.
- R6: With sync_mode=1, dbl_speed has no effect. The master transfer clock and strobes are identical for dbl_speed=0 and dbl_speed=1.
- R7: In master mode (sync_mode=1, master_sel=1), xck_oe is 1. After a load, xck_out starts at 0 and toggles on each base tick, so its period is 2(D+1) cycles. rx_bit_en pulses in the cycle xck_out rises and tx_bit_en pulses in the cycle it falls.
- R8: In asynchronous modes and in slave mode (sync_mode=1, master_sel=0), xck_oe and xck_out are 0.
- R9: In slave mode, a rising edge on xck_in gives a single rx_bit_en pulse and a falling edge gives a single tx_bit_en pulse. If xck_in changes between edges E(n) and E(n+1), the pulse is high in the cycle after E(n+3). xck_in must hold each level for at least 2 system clock cycles.
- R10: sample_tick stays 0 in both synchronous modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | 12 | Divider reload value D; tick period is D+1 cycles |
| div_load | input | 1 | One-cycle strobe: divisor was written, restart timing |
| sync_mode | input | 1 | 0 = asynchronous, 1 = synchronous |
| dbl_speed | input | 1 | Asynchronous double speed (8 ticks per bit) |
| master_sel | input | 1 | Synchronous direction: 1 = drive transfer clock, 0 = follow it |
| xck_in | input | 1 | External transfer clock pin input (slave mode) |
| sample_tick | output | 1 | Oversampling strobe, asynchronous modes |
| tx_bit_en | output | 1 | Transmit bit-time enable |
| rx_bit_en | output | 1 | Receive bit-time enable |
| xck_out | output | 1 | Transfer clock driven in master mode |
| xck_oe | output | 1 | Output enable for the transfer clock pin |

## Verification
The bench sweeps small divisors, including D=0, where the tick must fire on every cycle. A reload that was off by one cycle, or that let a stale tick through, would shift every expected pulse. Both asynchronous ratios are swept to at least two bit periods, so a prescaler with the wrong wrap point or one that does not clear on load shows up as a misplaced bit strobe. Master mode is swept with double speed both off and on: if dbl_speed leaked into synchronous timing, the transfer clock period would halve. It also catches strobes attached to the wrong edge. A slave pattern with holds from two to six cycles checks the three-cycle synchronizer latency and the one-pulse-per-edge rule. A missing or extra synchronizer stage, or a level detector in place of an edge detector, would fail it.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;

   typedef enum logic [1:0] {
      CK_ASYNC_X16 = 2'd0,
      CK_ASYNC_X8  = 2'd1,
      CK_SYNC_MST  = 2'd2,
      CK_SYNC_SLV  = 2'd3
   } ck_mode_e;

   // Double speed is only meaningful when asynchronous.
   function automatic ck_mode_e ck_decode(input logic sync, input logic dbl, input logic mst);
      if (sync) return mst ? CK_SYNC_MST : CK_SYNC_SLV;
      return dbl ? CK_ASYNC_X8 : CK_ASYNC_X16;
   endfunction

endpackage

// File: rtl/usart_baud_div.sv
module usart_baud_div #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   input  logic             div_load,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (div_load) begin
         cnt  <= divisor;
         tick <= 1'b0;
      end else if (cnt == '0) begin
         cnt  <= divisor;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt - 1'b1;
         tick <= 1'b0;
      end
   end

endmodule

// File: rtl/usart_async_pre.sv
module usart_async_pre #(
   parameter int OVS_NORM = 16,
   parameter int OVS_DBL  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic dbl,
   output logic bit_end
);

   localparam int PW = $clog2(OVS_NORM);
   localparam logic [PW-1:0] LIM_NORM = PW'(OVS_NORM - 1);
   localparam logic [PW-1:0] LIM_DBL  = PW'(OVS_DBL - 1);

   logic [PW-1:0] pre;
   logic [PW-1:0] lim;

   assign lim     = dbl ? LIM_DBL : LIM_NORM;
   assign bit_end = tick && (pre == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         pre <= '0;
      end else if (tick) begin
         pre <= bit_end ? '0 : pre + 1'b1;
      end
   end

endmodule

// File: rtl/usart_xck_sync.sv
module usart_xck_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xck_in,
   output logic rise,
   output logic fall
);

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= xck_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
   import usart_clkgen_pkg::*;
#(
   parameter int DIV_W       = 12,
   parameter int OVS_NORM    = 16,
   parameter int OVS_DBL     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   input  logic             div_load,
   input  logic             sync_mode,
   input  logic             dbl_speed,
   input  logic             master_sel,
   input  logic             xck_in,
   output logic             sample_tick,
   output logic             tx_bit_en,
   output logic             rx_bit_en,
   output logic             xck_out,
   output logic             xck_oe
);

   generate
      if (DIV_W < 2) begin : g_bad_div_w
         $error("usart_clkgen: DIV_W must be at least 2");
      end
      if (OVS_NORM < 2 || (OVS_NORM & (OVS_NORM - 1)) != 0) begin : g_bad_ovs
         $error("usart_clkgen: OVS_NORM must be a power of two");
      end
      if (OVS_DBL < 1 || OVS_DBL > OVS_NORM) begin : g_bad_dbl
         $error("usart_clkgen: OVS_DBL must lie in 1..OVS_NORM");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("usart_clkgen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   ck_mode_e mode;
   logic     base_tick;
   logic     bit_end;
   logic     ext_rise;
   logic     ext_fall;
   logic     xck_q;

   assign mode = ck_decode(sync_mode, dbl_speed, master_sel);

   usart_baud_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .divisor  (divisor),
      .div_load (div_load),
      .tick     (base_tick)
   );

   usart_async_pre #(.OVS_NORM(OVS_NORM), .OVS_DBL(OVS_DBL)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (div_load | sync_mode),
      .tick    (base_tick),
      .dbl     (dbl_speed),
      .bit_end (bit_end)
   );

   usart_xck_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .xck_in (xck_in),
      .rise   (ext_rise),
      .fall   (ext_fall)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sample_tick <= 1'b0;
         tx_bit_en   <= 1'b0;
         rx_bit_en   <= 1'b0;
         xck_q       <= 1'b0;
      end else begin
         unique case (mode)
            CK_ASYNC_X16, CK_ASYNC_X8: begin
               sample_tick <= base_tick & ~div_load;
               tx_bit_en   <= bit_end & ~div_load;
               rx_bit_en   <= bit_end & ~div_load;
               xck_q       <= 1'b0;
            end
            CK_SYNC_MST: begin
               sample_tick <= 1'b0;
               if (div_load) begin
                  xck_q     <= 1'b0;
                  tx_bit_en <= 1'b0;
                  rx_bit_en <= 1'b0;
               end else if (base_tick) begin
                  xck_q     <= ~xck_q;
                  tx_bit_en <= xck_q;
                  rx_bit_en <= ~xck_q;
               end else begin
                  tx_bit_en <= 1'b0;
                  rx_bit_en <= 1'b0;
               end
            end
            default: begin
               sample_tick <= 1'b0;
               tx_bit_en   <= ext_fall;
               rx_bit_en   <= ext_rise;
               xck_q       <= 1'b0;
            end
         endcase
      end
   end

   assign xck_out = xck_q;
   assign xck_oe  = rst_n && (mode == CK_SYNC_MST);

endmodule

// File: rtl/usart_clkgen_chk.sv
module usart_clkgen_chk (
   input logic clk,
   input logic rst_n,
   input logic sync_mode,
   input logic master_sel,
   input logic sample_tick,
   input logic tx_bit_en,
   input logic rx_bit_en,
   input logic xck_out
);

   // R10: no oversampling strobe while synchronous
   p_sync_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sync_mode) |-> !sample_tick);

   // R9: transmit and receive strobes never coincide in synchronous modes
   p_sync_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sync_mode) |-> $onehot0({tx_bit_en, rx_bit_en}));

   // R4: an asynchronous bit strobe always lands on a sample tick
   p_async_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sync_mode) && tx_bit_en) |-> sample_tick);

   // R7: master transmit strobe marks a falling transfer clock
   p_mst_tx_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sync_mode && master_sel) && tx_bit_en) |-> $fell(xck_out));

   // R7: master receive strobe marks a rising transfer clock
   p_mst_rx_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sync_mode && master_sel) && rx_bit_en) |-> $rose(xck_out));

endmodule

bind usart_clkgen usart_clkgen_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_mode   (sync_mode),
   .master_sel  (master_sel),
   .sample_tick (sample_tick),
   .tx_bit_en   (tx_bit_en),
   .rx_bit_en   (rx_bit_en),
   .xck_out     (xck_out)
);

// File: tb/usart_clkgen_bench.sv
`timescale 1ns/1ps
module usart_clkgen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] divisor = '0;
   logic        div_load = 1'b0;
   logic        sync_mode = 1'b0;
   logic        dbl_speed = 1'b0;
   logic        master_sel = 1'b0;
   logic        xck_in = 1'b0;
   logic        sample_tick, tx_bit_en, rx_bit_en, xck_out, xck_oe;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   usart_clkgen u_usart_clkgen (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .div_load(div_load),
      .sync_mode(sync_mode), .dbl_speed(dbl_speed), .master_sel(master_sel),
      .xck_in(xck_in), .sample_tick(sample_tick), .tx_bit_en(tx_bit_en),
      .rx_bit_en(rx_bit_en), .xck_out(xck_out), .xck_oe(xck_oe)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t actual=%0b expected=%0b", tag, $time, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   // Load divisor D with a mode, then compare each cycle against the arithmetic model.
   task automatic load_mode(input int d, input logic s, input logic db, input logic m);
      @(negedge clk);
      sync_mode  = s;
      dbl_speed  = db;
      master_sel = m;
      divisor    = 12'(d);
      div_load   = 1'b1;
      @(negedge clk);
      div_load   = 1'b0;
   endtask

   task automatic run_async(input int d, input logic db);
      int ovs = db ? 8 : 16;
      int ncyc = 2 * ovs * (d + 1) + d + 4;
      string bt = db ? "R5" : "R4";
      load_mode(d, 1'b0, db, 1'b0);
      for (int c = 1; c <= ncyc; c++) begin
         logic is_t, is_b;
         int k;
         @(negedge clk);
         is_t = (c >= d + 2) && (((c - d - 2) % (d + 1)) == 0);
         k    = (c >= d + 2) ? (c - d - 2) / (d + 1) : 0;
         is_b = is_t && ((k % ovs) == ovs - 1);
         chk(sample_tick, is_t, $sformatf("R2 R3 sample_tick D=%0d c=%0d", d, c));
         chk(tx_bit_en, is_b, $sformatf("%s tx_bit_en D=%0d c=%0d", bt, d, c));
         chk(rx_bit_en, is_b, $sformatf("%s rx_bit_en D=%0d c=%0d", bt, d, c));
         chk(xck_oe, 1'b0, "R8 xck_oe async");
         chk(xck_out, 1'b0, "R8 xck_out async");
      end
   endtask

   task automatic run_master(input int d, input logic db);
      int ncyc = 6 * (d + 1) + d + 4;
      string tg = db ? "R6" : "R7";
      load_mode(d, 1'b1, db, 1'b1);
      for (int c = 1; c <= ncyc; c++) begin
         logic is_t;
         int k, n;
         @(negedge clk);
         is_t = (c >= d + 2) && (((c - d - 2) % (d + 1)) == 0);
         k    = (c >= d + 2) ? (c - d - 2) / (d + 1) : 0;
         n    = (c >= d + 2) ? k + 1 : 0;
         chk(xck_out, 1'((n % 2) == 1), $sformatf("%s xck_out D=%0d c=%0d", tg, d, c));
         chk(rx_bit_en, is_t && ((k % 2) == 0), $sformatf("%s rx_bit_en D=%0d c=%0d", tg, d, c));
         chk(tx_bit_en, is_t && ((k % 2) == 1), $sformatf("%s tx_bit_en D=%0d c=%0d", tg, d, c));
         chk(xck_oe, 1'b1, "R7 xck_oe master");
         chk(sample_tick, 1'b0, "R10 sample_tick master");
      end
   endtask

   task automatic run_slave();
      logic d1 = 1'b0, d2 = 1'b0, d3 = 1'b0, d4 = 1'b0;
      logic lvl = 1'b0;
      int   hold = 0;
      int   seg = 0;
      @(negedge clk);
      sync_mode  = 1'b1;
      master_sel = 1'b0;
      dbl_speed  = 1'b1;
      xck_in     = 1'b0;
      repeat (6) @(negedge clk);
      for (int m = 0; m < 120; m++) begin
         @(negedge clk);
         chk(rx_bit_en, d3 & ~d4, $sformatf("R9 rx_bit_en step=%0d", m));
         chk(tx_bit_en, ~d3 & d4, $sformatf("R9 tx_bit_en step=%0d", m));
         chk(sample_tick, 1'b0, "R10 sample_tick slave");
         chk(xck_oe, 1'b0, "R8 xck_oe slave");
         chk(xck_out, 1'b0, "R8 xck_out slave");
         if (hold == 0) begin
            lvl  = ~lvl;
            hold = 2 + (seg % 5);
            seg++;
         end
         hold--;
         xck_in = (m < 112) ? lvl : 1'b0;
         d4 = d3; d3 = d2; d2 = d1; d1 = xck_in;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(sample_tick, 1'b0, "R1 sample_tick in reset");
      chk(tx_bit_en, 1'b0, "R1 tx_bit_en in reset");
      chk(rx_bit_en, 1'b0, "R1 rx_bit_en in reset");
      chk(xck_out, 1'b0, "R1 xck_out in reset");
      chk(xck_oe, 1'b0, "R1 xck_oe in reset");
      @(negedge clk);
      rst_n = 1'b1;
      for (int d = 0; d <= 5; d++) run_async(d, 1'b0);
      for (int d = 0; d <= 5; d++) run_async(d, 1'b1);
      for (int d = 0; d <= 4; d++) begin
         run_master(d, 1'b0);
         run_master(d, 1'b1);
      end
      run_slave();
      run_async(3, 1'b0);
      summary();
      $finish;
   end

endmodule